// File: doc/BRIEF.md
# Dual-Modulus Divide-by-2/3 Prescaler

This block divides its input clock by two or by three under a single divide-select input. It holds two bits of state: a hold stage and an output stage. The output stage produces the divided signal. Its next state is the AND of its own inverted value and the inverted hold-stage value, so no separate inverter stage sits between the two bits. The hold stage only takes part in the divide-by-three cycle. While divide-by-two is selected it is loaded with zero once and then its enable is switched off, so it does not toggle.

The block is meant to sit in the feedback path of a frequency synthesiser, where a controller changes the modulus from pulse to pulse. The select input is sampled on every rising edge. The length of each low gap in the output is fixed by the select value at the edge on which the output falls. Reset is asserted asynchronously and active-low. It is released through a short synchroniser, so the divider starts on a clean clock edge.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While `rst_n` is low, `div_o` is 0. Once `rst_n` has been released, `div_o` first rises on the (SYNC_STAGES+1)-th rising clock edge, which is the third edge for the default SYNC_STAGES = 2.
- R2: With `dc` held at 1 (divide-by-two), `div_o` has a period of 2 input cycles: high for one cycle, then low for one.
- R3: With `dc` held at 0 (divide-by-three), `div_o` has a period of 3 input cycles and is high for exactly one of them. In no mode is `div_o` high for two consecutive cycles.
- R4: The low gap after each high pulse is decided by `dc` at the rising edge on which `div_o` falls. A value of 0 gives two low cycles and a value of 1 gives one. Any change of `dc` during the gap does not alter the gap.
- R5: While `dc` is 1, the hold stage is cleared at the next edge and then stays still. On a return to `dc` = 0 the output therefore continues in the cycle-exact sequence of a cleared hold stage.
- R6: Once `div_o` has risen after reset, it is never low for more than two consecutive cycles under any pattern on `dc`. After any change of `dc`, the new period is in place within three input cycles.
- R7: Driving `rst_n` low forces `div_o` to 0 immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| dc | input | 1 | Divide select: 1 selects divide-by-two, 0 selects divide-by-three |
| div_o | output | 1 | Divided clock output |

## Verification
The bench goes after the gap decision at the falling edge of the output. It toggles `dc` every cycle and also drives it in a pseudo-random pattern. A design that sampled `dc` at the wrong edge would stretch or shorten a gap one pulse late. The bench also returns from divide-by-two to divide-by-three at each phase. A hold stage that was not cleared and frozen would block the output stage, and the output would stick low. Reset is released between edges and asserted while the output is high. This exposes a synchroniser with the wrong depth, which gives a late or early first pulse, and a reset that waits for a clock edge.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic {
    MODE_DIV3 = 1'b0,
    MODE_DIV2 = 1'b1
  } mode_e;
endpackage

// File: rtl/dmp_rst_sync.sv
module dmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dmp_hold_stage.sv
module dmp_hold_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rst_n,
  input  logic div2_sel,
  input  logic fb_i,
  output logic hold_q
);
  logic en;
  logic nxt;

  // Gating at the input: loads zero once in divide-by-two, then disabled.
  always_comb begin
    en  = !div2_sel || hold_q;
    nxt = div2_sel ? 1'b0 : fb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= 1'b0;
    else if (!sync_rst_n) hold_q <= 1'b0;
    else if (en)         hold_q <= nxt;
  end
endmodule

// File: rtl/dmp_out_stage.sv
module dmp_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rst_n,
  input  logic hold_i,
  output logic out_q
);
  logic nxt;

  // AND term with the hold value taken inverted: no separate inverter stage.
  always_comb nxt = !out_q && !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          out_q <= 1'b0;
    else if (!sync_rst_n) out_q <= 1'b0;
    else                 out_q <= nxt;
  end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dc,
  output logic div_o
);
  localparam int SyncDepth = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  mode_e mode;
  logic  div2_sel;
  logic  sync_rst_n;
  logic  hold_q;
  logic  out_q;

  always_comb begin
    mode     = mode_e'(dc);
    div2_sel = (mode == MODE_DIV2);
  end

  dmp_rst_sync #(.STAGES(SyncDepth)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(sync_rst_n)
  );

  dmp_hold_stage u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_rst_n(sync_rst_n),
    .div2_sel  (div2_sel),
    .fb_i      (out_q),
    .hold_q    (hold_q)
  );

  dmp_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_rst_n(sync_rst_n),
    .hold_i    (hold_q),
    .out_q     (out_q)
  );

  assign div_o = out_q;
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker (
  input logic clk,
  input logic rst_n,
  input logic dc,
  input logic div_o,
  input logic hold_q
);
  logic seen_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_high <= 1'b0;
    else if (div_o) seen_high <= 1'b1;
  end

  // R1 / R7: output low whenever reset is driven
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_low_r1: assert (div_o == 1'b0);
    end
  end

  p_single_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_o |=> !div_o);

  p_gap_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_o) && $past(dc)) |=> div_o);

  p_gap_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_o) && !$past(dc)) |=> !div_o ##1 div_o);

  p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dc |=> !hold_q);

  p_low_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_high && !div_o && $past(!div_o)) |=> div_o);
endmodule

bind dual_mod_prescaler dmp_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .dc    (dc),
  .div_o (div_o),
  .hold_q(hold_q)
);

// File: tb/dual_mod_prescaler_tb_top.sv
module dual_mod_prescaler_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic dc;
  logic div_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference: out level, cycles low since pulse, gap length chosen
  bit m_out;
  int m_low;
  int m_gap;
  int m_rel;

  int cyc = 0;
  int last_rise = -1;
  int meas_exp = 0;
  bit prev_out = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dual_mod_prescaler #(.SYNC_STAGES(SYNC)) dut_i (
    .clk  (clk),
    .rst_n(rst_n),
    .dc   (dc),
    .div_o(div_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: div_o=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_out = 0; m_low = 2; m_gap = 2; m_rel = 0;
  endtask

  task automatic model_edge(input logic dcv);
    if (m_rel < SYNC) begin
      m_rel++;
      m_out = 0; m_low = 2; m_gap = 2;
    end else if (m_out) begin
      m_out = 0; m_low = 1; m_gap = dcv ? 1 : 2;
    end else if (m_low < m_gap) begin
      m_low++;
    end else begin
      m_out = 1;
    end
  endtask

  task automatic step(input logic dcv, input string tag);
    dc = dcv;
    @(posedge clk);
    model_edge(dcv);
    cyc++;
    @(negedge clk);
    chk(tag, div_o, m_out);
    if (div_o && !prev_out) begin
      if (meas_exp != 0 && last_rise >= 0) begin
        checks++;
        if (cyc - last_rise != meas_exp) begin
          fails++;
          $display("FAIL %s period: got %0d expected %0d", tag, cyc - last_rise, meas_exp);
        end
      end
      last_rise = cyc;
    end
    prev_out = div_o;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      chk("R1 in reset", div_o, 1'b0);
    end
    rst_n = 1'b1;
    prev_out = 0;
    last_rise = -1;
  endtask

  initial begin
    dc = 1'b1;
    do_reset();
    // R1: first rise on edge SYNC+1
    for (int i = 0; i < SYNC + 1; i++) step(1'b1, "R1 release");
    chk("R1 first rise", div_o, 1'b1);

    // R2: steady divide-by-two
    meas_exp = 0;
    for (int i = 0; i < 3; i++) step(1'b1, "R2");
    last_rise = -1; meas_exp = 2;
    for (int i = 0; i < 20; i++) step(1'b1, "R2 div2");

    // R3: steady divide-by-three
    meas_exp = 0;
    for (int i = 0; i < 3; i++) step(1'b0, "R6 settle");
    last_rise = -1; meas_exp = 3;
    for (int i = 0; i < 30; i++) step(1'b0, "R3 div3");
    meas_exp = 0;

    // R4: toggle every cycle
    for (int i = 0; i < 40; i++) step(logic'(i % 2), "R4 toggle");
    for (int i = 0; i < 40; i++) step(logic'((i / 3) % 2), "R4 slow toggle");

    // R5: return from divide-by-two at each phase
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 4 + p; i++) step(1'b1, "R5 div2");
      for (int i = 0; i < 7; i++) step(1'b0, "R5 return");
    end

    // R6: pseudo-random mode changes
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "R6 random");
    end

    // R7: asynchronous reset while output is high
    while (!m_out) step(1'b0, "R7 seek");
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R7 async clear", div_o, 1'b0);
    @(negedge clk);
    do_reset();
    for (int i = 0; i < SYNC + 1; i++) step(1'b0, "R1 re-release");
    chk("R1 first rise again", div_o, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b0, "R3 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule